// File: doc/BRIEF.md
# Byte-Stream FPGA Configuration Loader

This block brings a target FPGA out of its configuration reset and feeds it a configuration image one byte at a time. A `start` pulse makes it hold the device's clear output low for a fixed number of clocks. It then releases the output and waits for the device to report that it is ready. The controller builds the byte stream itself. It sends an 8-byte header, then cuts the payload from an upstream valid/ready source into fixed 28-byte frames, and closes with four startup bytes. The source supplies only raw payload bytes. It marks the final one with `src_last`.

Outgoing bytes leave on a valid/ready port. `out_valid` stays high with `out_data` unchanged until `out_ready` accepts the byte. Payload bytes go straight through with no storage. In a payload slot, `out_valid` follows `src_valid`, `out_data` follows `src_data`, and `src_ready` follows `out_ready`. The source must therefore hold `src_valid` and `src_data` steady until `src_ready` accepts them. Back-pressure from either side stalls the stream and drops no byte. At each frame boundary the controller samples the device's ready and complete inputs to decide whether to send another frame. At the end it reports pass or fail and goes idle. A later `start` runs the whole sequence again.

Top module: `cfg_streamer`

## Requirements
- R1: After reset, `dev_reset_n`=1, `out_valid`=0, `src_ready`=0, `busy`=0, `load_ok`=0 and `load_err`=0.
- R2: A `start` pulse while not busy drives `dev_reset_n` low for exactly PROG_CYCLES clocks and then high. `busy` is high from the next clock until the result is posted.
- R3: After `dev_reset_n` is released, no byte is offered until `dev_busy_n` is seen high through a SYNC_STAGES-flop synchroniser. If it is not seen high within INIT_TIMEOUT clocks, the controller sets `load_err`=1, drops `busy` and offers no byte.
- R4: The header is the 8 bytes 0xFF, 0xFF, 0xFF, 0x4F, 0x80, 0xAF, 0x9B, 0x4B, in that order. The first 0xFF is a throw-away byte.
- R5: Each frame is 28 bytes. Position 0 is 0x4F. Positions 1 to 21 carry payload. Positions 22 to 27 are 0x4B, 0xFF, 0x4B, 0xFF, 0xFF, 0xFF.
- R6: After the source byte flagged `src_last` is taken, the remaining payload positions of that frame are 0xFF. `src_ready` stays 0 from then on.
- R7: A new frame starts, after the header or after a frame, only when the synchronised `dev_busy_n` is 1, the synchronised `dev_complete` is 0 and the last payload byte has not yet been taken.
- R8: Exactly four 0xFF startup bytes follow the last frame, including when frames stopped early.
- R9: After the startup bytes, `load_ok`=1 if the synchronised `dev_complete` is 1 and frames did not stop because `dev_busy_n` was low while payload remained. Otherwise `load_err`=1. `busy` then drops and the result holds until the next `start`.
- R10: Under back-pressure, an offered byte stays valid with unchanged data until accepted. `src_ready` is high only when `out_ready` is high.
- R11: If `dev_complete` rises during loading, no further frame starts, even if payload remains. The load ends with `load_ok`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin a configuration run |
| src_data | input | 8 | Payload byte from source |
| src_valid | input | 1 | Source byte valid |
| src_last | input | 1 | Marks the final payload byte |
| src_ready | output | 1 | Payload byte accepted |
| out_data | output | 8 | Byte to the device port |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Device port accepts the byte |
| dev_reset_n | output | 1 | Active-low configuration clear to device |
| dev_busy_n | input | 1 | Low while device is clearing or has flagged an error |
| dev_complete | input | 1 | High when device reports configuration finished |
| busy | output | 1 | Run in progress |
| load_ok | output | 1 | Last run succeeded |
| load_err | output | 1 | Last run failed |

## Verification
The hardest case to reach from the ports is an early stop. In that case the ready input drops while payload is still waiting, and the frame in flight must still finish whole, followed by the trailer and a failure flag. The bench counts accepted output bytes and lowers the ready input partway through the second frame. This leaves the synchroniser settled well before the frame boundary where the decision is taken. The same byte-count trigger raises the complete input partway through the first frame, to check an early, successful end. Random gaps on both valid and ready exercise stalls on fixed and payload bytes.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

  localparam int BYTE_W    = 8;
  localparam int HDR_LEN   = 8;
  localparam int PAY_FIRST = 1;
  localparam int PAY_LEN   = 21;
  localparam int FRAME_LEN = 28;
  localparam int TRAIL_LEN = 4;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  localparam logic [BYTE_W-1:0] B_FILL  = 8'hFF;
  localparam logic [BYTE_W-1:0] B_SYNC  = 8'h4F;
  localparam logic [BYTE_W-1:0] B_CHECK = 8'h4B;

  localparam logic [IDX_W-1:0] IX_HDR_LAST   = IDX_W'(HDR_LEN - 1);
  localparam logic [IDX_W-1:0] IX_FRM_LAST   = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] IX_TRL_LAST   = IDX_W'(TRAIL_LEN - 1);
  localparam logic [IDX_W-1:0] IX_PAY_FIRST  = IDX_W'(PAY_FIRST);
  localparam logic [IDX_W-1:0] IX_PAY_END    = IDX_W'(PAY_FIRST + PAY_LEN);
  localparam logic [IDX_W-1:0] IX_CHECK2     = IDX_W'(PAY_FIRST + PAY_LEN + 2);

  typedef enum logic [3:0] {
    ST_IDLE, ST_PROG, ST_WAIT_RDY, ST_HEADER, ST_DECIDE,
    ST_FRAME, ST_TRAILER, ST_CHECK, ST_END
  } cfg_state_e;

  typedef enum logic [1:0] {PH_NONE, PH_HDR, PH_FRAME, PH_TRAIL} cfg_phase_e;

  function automatic logic [BYTE_W-1:0] hdr_byte(input logic [IDX_W-1:0] ix);
    case (ix)
      IDX_W'(3): hdr_byte = B_SYNC;
      IDX_W'(4): hdr_byte = 8'h80;
      IDX_W'(5): hdr_byte = 8'hAF;
      IDX_W'(6): hdr_byte = 8'h9B;
      IDX_W'(7): hdr_byte = B_CHECK;
      default:   hdr_byte = B_FILL;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] frame_fixed(input logic [IDX_W-1:0] ix);
    if (ix == '0)                                frame_fixed = B_SYNC;
    else if (ix == IX_PAY_END || ix == IX_CHECK2) frame_fixed = B_CHECK;
    else                                         frame_fixed = B_FILL;
  endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d};
      end
    end
  endgenerate

  assign q = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/cfg_timer.sv
module cfg_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/cfg_pattern.sv
module cfg_pattern
  import cfg_stream_pkg::*;
(
  input  cfg_phase_e        phase,
  input  logic [IDX_W-1:0]  idx,
  output logic [BYTE_W-1:0] fixed_byte,
  output logic              is_payload
);
  always_comb begin
    fixed_byte = B_FILL;
    is_payload = 1'b0;
    case (phase)
      PH_HDR:   fixed_byte = hdr_byte(idx);
      PH_FRAME: begin
        if (idx >= IX_PAY_FIRST && idx < IX_PAY_END) is_payload = 1'b1;
        else                                          fixed_byte = frame_fixed(idx);
      end
      default:  fixed_byte = B_FILL;
    endcase
  end
endmodule

// File: rtl/cfg_streamer.sv
module cfg_streamer
  import cfg_stream_pkg::*;
#(
  parameter int PROG_CYCLES  = 1250,
  parameter int INIT_TIMEOUT = 250000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] src_data,
  input  logic              src_valid,
  input  logic              src_last,
  output logic              src_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              dev_reset_n,
  input  logic              dev_busy_n,
  input  logic              dev_complete,
  output logic              busy,
  output logic              load_ok,
  output logic              load_err
);
  localparam int TMAX = (PROG_CYCLES > INIT_TIMEOUT) ? PROG_CYCLES : INIT_TIMEOUT;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] PROG_LOAD = TW'(PROG_CYCLES - 1);
  localparam logic [TW-1:0] WAIT_LOAD = TW'(INIT_TIMEOUT - 1);

  cfg_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic              last_seen_q, early_q, ok_q, err_q;
  logic              rdy_s, cmpl_s;
  logic              tmr_load, tmr_zero;
  logic [TW-1:0]     tmr_val;
  cfg_phase_e        phase;
  logic [BYTE_W-1:0] fixed_byte;
  logic              is_payload, out_fire, src_fire, slot_last;

  cfg_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({dev_complete, dev_busy_n}), .q({cmpl_s, rdy_s})
  );

  cfg_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_zero)
  );

  cfg_pattern u_pat (
    .phase(phase), .idx(idx_q), .fixed_byte(fixed_byte), .is_payload(is_payload)
  );

  always_comb begin
    case (state_q)
      ST_HEADER:  phase = PH_HDR;
      ST_FRAME:   phase = PH_FRAME;
      ST_TRAILER: phase = PH_TRAIL;
      default:    phase = PH_NONE;
    endcase
  end

  // Output byte mux: payload slots are passed straight through from the source.
  always_comb begin
    out_valid = 1'b0;
    out_data  = fixed_byte;
    src_ready = 1'b0;
    case (state_q)
      ST_HEADER, ST_TRAILER: out_valid = 1'b1;
      ST_FRAME: begin
        if (is_payload && !last_seen_q) begin
          out_valid = src_valid;
          out_data  = src_data;
          src_ready = out_ready;
        end else begin
          out_valid = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign out_fire = out_valid && out_ready;
  assign src_fire = src_valid && src_ready;

  always_comb begin
    case (state_q)
      ST_HEADER:  slot_last = (idx_q == IX_HDR_LAST);
      ST_FRAME:   slot_last = (idx_q == IX_FRM_LAST);
      ST_TRAILER: slot_last = (idx_q == IX_TRL_LAST);
      default:    slot_last = 1'b0;
    endcase
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = PROG_LOAD;
    if ((state_q == ST_IDLE || state_q == ST_END) && start) begin
      tmr_load = 1'b1;
    end else if (state_q == ST_PROG && tmr_zero) begin
      tmr_load = 1'b1;
      tmr_val  = WAIT_LOAD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      last_seen_q <= 1'b0;
      early_q     <= 1'b0;
      ok_q        <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      if (src_fire && src_last) last_seen_q <= 1'b1;
      case (state_q)
        ST_IDLE, ST_END: if (start) begin
          state_q     <= ST_PROG;
          last_seen_q <= 1'b0;
          early_q     <= 1'b0;
          ok_q        <= 1'b0;
          err_q       <= 1'b0;
        end
        ST_PROG: if (tmr_zero) state_q <= ST_WAIT_RDY;
        ST_WAIT_RDY: begin
          if (rdy_s) begin
            state_q <= ST_HEADER;
            idx_q   <= '0;
          end else if (tmr_zero) begin
            state_q <= ST_END;
            err_q   <= 1'b1;
          end
        end
        ST_DECIDE: begin
          idx_q <= '0;
          if (rdy_s && !cmpl_s && !last_seen_q) begin
            state_q <= ST_FRAME;
          end else begin
            state_q <= ST_TRAILER;
            early_q <= !rdy_s && !last_seen_q;
          end
        end
        ST_HEADER, ST_FRAME, ST_TRAILER: if (out_fire) begin
          if (slot_last) begin
            state_q <= (state_q == ST_TRAILER) ? ST_CHECK : ST_DECIDE;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_CHECK: begin
          state_q <= ST_END;
          ok_q    <= cmpl_s && !early_q;
          err_q   <= !(cmpl_s && !early_q);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dev_reset_n = (state_q != ST_PROG);
  assign busy        = (state_q != ST_IDLE) && (state_q != ST_END);
  assign load_ok     = ok_q;
  assign load_err    = err_q;

  // Width of the clear pulse, counted independently of the timer.
  logic [TW:0] low_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            low_cnt_q <= '0;
    else if (dev_reset_n)  low_cnt_q <= '0;
    else if (low_cnt_q != '1) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assert_clear_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_reset_n) |-> (low_cnt_q == (TW+1)'(PROG_CYCLES)));

  assert_hold_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_src_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> out_ready);

  assert_no_pull_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> !last_seen_q);

  assert_result_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_ok && load_err));

  assert_quiet_in_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_reset_n |-> !out_valid);

endmodule

// File: tb/test_cfg_streamer.sv
`timescale 1ns/1ps
module test_cfg_streamer;
  localparam int PROG = 12;
  localparam int TMO  = 60;

  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] src_data = 0;
  logic src_valid = 0, src_last = 0, out_ready = 0;
  logic dev_busy_n = 0, dev_complete = 0;
  logic src_ready, out_valid, dev_reset_n, busy, load_ok, load_err;
  logic [7:0] out_data;

  cfg_streamer #(.PROG_CYCLES(PROG), .INIT_TIMEOUT(TMO), .SYNC_STAGES(2)) i_cfg_streamer (
    .clk(clk), .rst_n(rst_n), .start(start), .src_data(src_data), .src_valid(src_valid),
    .src_last(src_last), .src_ready(src_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .dev_reset_n(dev_reset_n), .dev_busy_n(dev_busy_n),
    .dev_complete(dev_complete), .busy(busy), .load_ok(load_ok), .load_err(load_err)
  );

  initial forever #4 clk = ~clk;

  int nchk = 0, nerr = 0;
  int exp_q[$];
  int src_q[$];
  int acc_cnt = 0, consumed = 0, early_bytes = 0;
  int init_dly = -1, drop_at = -1, done_at = -1, rdy_mode = 0, gap_mode = 0;
  int plow = 0, last_plow = 0, rel_cnt = 0;
  bit dropped = 0, ready_seen = 0, run_bench = 0;
  bit prev_stall = 0;
  logic [7:0] prev_data = 0;
  int unsigned lfsr = 32'h1234_5678;

  task automatic check(bit cond, string req, string what, int act, int expv);
    nchk++;
    if (!cond) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int pay(int p);
    return (p * 37 + 5) & 255;
  endfunction

  // Cycle loop: device model, source, sink, and reference comparison.
  initial begin
    forever begin
      @(negedge clk);
      if (run_bench) begin
        lfsr = lfsr * 1103515245 + 12345;
        // device model
        if (!dev_reset_n) begin
          dev_busy_n = 0; dev_complete = 0; dropped = 0; rel_cnt = 0; plow++;
        end else begin
          if (plow > 0) begin last_plow = plow; plow = 0; end
          rel_cnt++;
          if (init_dly >= 0 && rel_cnt >= init_dly && !dropped) dev_busy_n = 1;
          if (drop_at >= 0 && acc_cnt >= drop_at) begin dev_busy_n = 0; dropped = 1; end
          if (done_at >= 0 && acc_cnt >= done_at) dev_complete = 1;
        end
        // source: hold an offered byte until taken
        if (src_q.size() == 0) src_valid = 0;
        else if (!src_valid) src_valid = (gap_mode == 0) || lfsr[20];
        if (src_q.size() > 0) src_data = 8'(src_q[0]);
        src_last = (src_q.size() == 1);
        out_ready = (rdy_mode == 0) || lfsr[25];
        #1;
        // R10: stalled byte must still be there
        if (prev_stall)
          check(out_valid && out_data == prev_data, "R10", "stalled byte held", int'(out_data), int'(prev_data));
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
        if (out_valid && !ready_seen) early_bytes++;
        if (dev_busy_n && dev_reset_n) ready_seen = 1;
        if (!dev_reset_n) ready_seen = 0;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) check(0, "R8", "unexpected extra byte", int'(out_data), -1);
          else begin
            check(int'(out_data) == exp_q[0], "R5", $sformatf("byte %0d", acc_cnt), int'(out_data), exp_q[0]);
            void'(exp_q.pop_front());
          end
          acc_cnt++;
        end
        if (src_valid && src_ready) begin
          void'(src_q.pop_front());
          consumed++;
        end
      end
    end
  end

  task automatic build(int npay, int nfr);
    int hdr[8] = '{255, 255, 255, 'h4F, 'h80, 'hAF, 'h9B, 'h4B};
    exp_q.delete(); src_q.delete();
    for (int i = 0; i < npay; i++) src_q.push_back(pay(i));
    for (int i = 0; i < 8; i++) exp_q.push_back(hdr[i]);
    for (int f = 0; f < nfr; f++) begin
      exp_q.push_back('h4F);
      for (int k = 0; k < 21; k++) exp_q.push_back((f*21+k < npay) ? pay(f*21+k) : 255);
      exp_q.push_back('h4B); exp_q.push_back(255); exp_q.push_back('h4B);
      exp_q.push_back(255); exp_q.push_back(255); exp_q.push_back(255);
    end
    for (int i = 0; i < 4; i++) exp_q.push_back(255);
  endtask

  task automatic run_case(string name, int npay, int nfr, int idly, int drop, int done_rel,
                          int rmode, int gmode, bit exp_ok);
    int total = 8 + 28*nfr + 4;
    int lim = 0;
    int want_cons = (npay < 21*nfr) ? npay : 21*nfr;
    @(negedge clk);
    build(npay, nfr);
    acc_cnt = 0; consumed = 0; early_bytes = 0;
    init_dly = idly; drop_at = drop; rdy_mode = rmode; gap_mode = gmode;
    done_at = (done_rel == -2) ? total - 4 : done_rel;
    start = 1;
    @(negedge clk);
    start = 0;
    check(busy == 1, "R2", {name, " busy after start"}, int'(busy), 1);
    while (busy && lim < 20000) begin @(negedge clk); lim++; end
    check(lim < 20000, "R9", {name, " run ends"}, lim, 0);
    check(last_plow == PROG, "R2", {name, " clear width"}, last_plow, PROG);
    check(early_bytes == 0, "R3", {name, " no byte before ready"}, early_bytes, 0);
    check(idly < 0 ? acc_cnt == 0 : acc_cnt == total, "R8", {name, " byte count"}, acc_cnt, idly < 0 ? 0 : total);
    check(idly < 0 || exp_q.size() == 0, "R7", {name, " all expected bytes sent"}, exp_q.size(), 0);
    check(idly < 0 ? consumed == 0 : consumed == want_cons, "R6", {name, " payload taken"}, consumed, idly < 0 ? 0 : want_cons);
    check(load_ok == exp_ok && load_err == !exp_ok, "R9", {name, " result"}, {load_ok, load_err}, {exp_ok, !exp_ok});
    src_q.delete();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(dev_reset_n == 1 && out_valid == 0 && src_ready == 0, "R1", "reset outputs", {dev_reset_n, out_valid, src_ready}, 4);
    check(busy == 0 && load_ok == 0 && load_err == 0, "R1", "reset status", {busy, load_ok, load_err}, 0);
    rst_n = 1;
    run_bench = 1;
    repeat (3) @(negedge clk);
    // R4 R5 R10: three frames, last padded, random stalls both sides
    run_case("multi", 45, 3, 7, -1, -2, 1, 1, 1);
    // R5: payload fills exactly one frame
    run_case("exact21", 21, 1, 3, -1, -2, 0, 0, 1);
    // R6: single payload byte, twenty pads
    run_case("single", 1, 1, 5, -1, -2, 1, 0, 1);
    // R9: complete never rises
    run_case("nodone", 30, 2, 4, -1, -1, 0, 1, 0);
    // R7 R8 R9: ready drops in frame two, trailer still sent, failure
    run_case("drop", 60, 2, 4, 8+28+10, 8+56, 0, 0, 0);
    // R11: complete rises in frame one, stream stops with success
    run_case("early_done", 60, 1, 4, -1, 18, 1, 0, 1);
    // R3: device never ready, timeout
    run_case("timeout", 10, 0, -1, -1, -1, 0, 0, 0);
    // R2 R5: restart after failure, two frames
    run_case("restart", 22, 2, 6, -1, -2, 1, 1, 1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    nerr++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule